// File: doc/BRIEF.md
# Tag-Synchronised Prefix-Sum Engine

This block forms the inclusive running sums of P numbers. It loads all P numbers at once and gives each one to its own worker lane. The lanes then share a scratch store in which every word carries a full/empty tag. The lanes are not stepped together in lockstep. Each lane advances on its own and stalls only when a word it wants to read is still empty. The order in which lanes finish therefore depends on the data and on arbitration.

The scratch store is organised as log2(P) levels by P columns, and each lane owns one column. On a level with stride h, lane i (counting from 0) takes two steps, writing first and then reading:
- It publishes its running sum into its own column when i < P - h.
- It then adds in the word at column i - h of the same level when i >= h, waiting until that word is full.

The stride starts at 1 and doubles after every level. The store has one write port and one read port. Each port is shared among the lanes by its own round-robin arbiter. A read that finds its word empty is simply requested again on a later cycle.

A start pulse clears every tag and every lane, and it loads new inputs, even while a run is still in progress. When every lane has finished every level, the done flag rises. Any lane's sum can then be read by presenting its index.

Top module: `pfx_engine`

## Requirements
- R1: After reset, done_o is 0.
- R2: When done_o is 1, presenting index k on rd_idx_i shows on rd_data_o the inclusive sum of inputs 0..k, where input k occupies bits [k*W +: W] of load_data_i.
- R3: Sums wrap modulo 2^W.
- R4: Once done_o is 1, it stays 1 until the next start pulse.
- R5: A start pulse given during a run discards all earlier tags and sums, and the new run's results depend only on the new inputs.
- R6: In the cycle after a start pulse, done_o is 0.
- R7: rd_data_o follows rd_idx_i combinationally, with no extra cycle of latency.
- R8: In each cycle, at most one lane is granted the write port and at most one lane is granted the read port. A grant is only given to a lane that is requesting.
- R9: A lane never adds in a scratch word whose tag is empty. A write sets the tag of its word to full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears tags and lanes, and loads load_data_i |
| load_data_i | input | P*W | Packed inputs; input k occupies bits [k*W +: W] |
| rd_idx_i | input | log2(P) | Index of the lane whose sum is shown |
| done_o | output | 1 | Every lane has finished all levels |
| rd_data_o | output | W | Running sum of the selected lane |

## Verification
A run's results are due at no fixed latency, because completion depends on which lanes stall on empty tags. The checks therefore key on done_o: after each start pulse, the bench polls done_o once per cycle between clock edges, up to a cycle bound. Only after done_o is seen high does it sweep rd_idx_i and read rd_data_o in that same cycle, since the result read has no register on its path. The clearing of done_o is due exactly one edge after start, and it is sampled there. The stickiness of done_o is sampled on several idle cycles after completion.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_WRITE = 2'd1,
        LN_READ  = 2'd2,
        LN_DONE  = 2'd3
    } lane_state_e;
endpackage

// File: rtl/pfx_rr_arb.sv
module pfx_rr_arb #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_d, ptr_q;

    always_comb begin
        logic found;
        found = 1'b0;
        gnt_o = '0;
        ptr_d = ptr_q;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % N;
            if (!found && req_i[idx]) begin
                found      = 1'b1;
                gnt_o[idx] = 1'b1;
                ptr_d      = IW'((idx + 1) % N);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/pfx_tagmem.sv
module pfx_tagmem #(
    parameter int DEPTH = 24,
    parameter int W     = 16,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o,
    output logic          rd_full_o
);
    typedef struct packed {
        logic [DEPTH-1:0]        tag;
        logic [DEPTH-1:0][W-1:0] word;
    } mem_t;

    mem_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.tag = '0;
        end else if (wr_en_i) begin
            st_d.tag[wr_addr_i]  = 1'b1;
            st_d.word[wr_addr_i] = wr_data_i;
        end
        rd_full_o = st_q.tag[rd_addr_i];
        rd_data_o = st_q.word[rd_addr_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_write_sets_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clear_i) |=> st_q.tag[$past(wr_addr_i)]);
    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.tag == '0));
endmodule

// File: rtl/pfx_lane.sv
module pfx_lane
    import pfx_pkg::*;
#(
    parameter int LANE   = 0,
    parameter int P      = 8,
    parameter int W      = 16,
    parameter int LEVELS = 3,
    parameter int LVW    = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   init_i,
    output logic           wr_req_o,
    input  logic           wr_gnt_i,
    output logic           rd_req_o,
    input  logic           rd_gnt_i,
    input  logic           rd_full_i,
    input  logic [W-1:0]   rd_data_i,
    output logic [LVW-1:0] level_o,
    output logic [W-1:0]   sum_o,
    output logic           done_o
);
    typedef struct packed {
        lane_state_e    state;
        logic [LVW-1:0] level;
        logic [W-1:0]   sum;
    } lane_t;

    lane_t r_d, r_q;
    logic  wr_need, rd_need, last_lvl;

    always_comb begin
        int hop;
        hop      = 1 << r_q.level;
        wr_need  = (LANE < P - hop);
        rd_need  = (LANE >= hop);
        last_lvl = (r_q.level == LVW'(LEVELS - 1));
        r_d      = r_q;
        wr_req_o = 1'b0;
        rd_req_o = 1'b0;
        if (start_i) begin
            r_d.state = LN_WRITE;
            r_d.level = '0;
            r_d.sum   = init_i;
        end else begin
            unique case (r_q.state)
                LN_WRITE: begin
                    if (wr_need) begin
                        wr_req_o = 1'b1;
                        if (wr_gnt_i) r_d.state = LN_READ;
                    end else begin
                        r_d.state = LN_READ;
                    end
                end
                LN_READ: begin
                    logic advance;
                    advance = 1'b0;
                    if (rd_need) begin
                        rd_req_o = 1'b1;
                        if (rd_gnt_i && rd_full_i) begin
                            r_d.sum = r_q.sum + rd_data_i;
                            advance = 1'b1;
                        end
                    end else begin
                        advance = 1'b1;
                    end
                    if (advance) begin
                        if (last_lvl) begin
                            r_d.state = LN_DONE;
                        end else begin
                            r_d.state = LN_WRITE;
                            r_d.level = r_q.level + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: LN_IDLE, level: '0, sum: '0};
        else        r_q <= r_d;
    end

    assign level_o = r_q.level;
    assign sum_o   = r_q.sum;
    assign done_o  = (r_q.state == LN_DONE);

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == LN_DONE && !start_i) |=> (r_q.state == LN_DONE));
    assert_sum_only_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(rd_gnt_i && rd_full_i)) |=> $stable(r_q.sum));
endmodule

// File: rtl/pfx_engine.sv
module pfx_engine #(
    parameter int P = 8,
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [P*W-1:0]         load_data_i,
    input  logic [$clog2(P)-1:0]   rd_idx_i,
    output logic                   done_o,
    output logic [W-1:0]           rd_data_o
);
    localparam int LEVELS = $clog2(P);
    localparam int LVW    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int DEPTH  = LEVELS * P;
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [P-1:0]   wr_req, wr_gnt, rd_req, rd_gnt, lane_done;
    logic [LVW-1:0] lane_level [P];
    logic [W-1:0]   lane_sum   [P];
    logic [AW-1:0]  wr_addr, rd_addr;
    logic [W-1:0]   wr_data, rd_data;
    logic           wr_en, rd_full;

    for (genvar g = 0; g < P; g++) begin : g_lane
        pfx_lane #(
            .LANE(g), .P(P), .W(W), .LEVELS(LEVELS), .LVW(LVW)
        ) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (start_i),
            .init_i    (load_data_i[g*W +: W]),
            .wr_req_o  (wr_req[g]),
            .wr_gnt_i  (wr_gnt[g]),
            .rd_req_o  (rd_req[g]),
            .rd_gnt_i  (rd_gnt[g]),
            .rd_full_i (rd_full),
            .rd_data_i (rd_data),
            .level_o   (lane_level[g]),
            .sum_o     (lane_sum[g]),
            .done_o    (lane_done[g])
        );
    end

    pfx_rr_arb #(.N(P)) wr_arb_i (
        .clk(clk), .rst_n(rst_n), .req_i(wr_req), .gnt_o(wr_gnt)
    );
    pfx_rr_arb #(.N(P)) rd_arb_i (
        .clk(clk), .rst_n(rst_n), .req_i(rd_req), .gnt_o(rd_gnt)
    );

    always_comb begin
        wr_addr = '0;
        wr_data = '0;
        rd_addr = '0;
        for (int l = 0; l < P; l++) begin
            if (wr_gnt[l]) begin
                wr_addr = AW'(int'(lane_level[l]) * P + l);
                wr_data = lane_sum[l];
            end
            if (rd_gnt[l]) begin
                rd_addr = AW'(int'(lane_level[l]) * P + l - (1 << lane_level[l]));
            end
        end
        wr_en = |wr_gnt;
    end

    pfx_tagmem #(.DEPTH(DEPTH), .W(W), .AW(AW)) mem_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .rd_full_o (rd_full)
    );

    assign done_o    = &lane_done;
    assign rd_data_o = lane_sum[rd_idx_i];

    assert_start_clears_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);
    assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
endmodule

// File: tb/pfx_engine_tb.sv
module pfx_engine_tb_top;
    localparam int P  = 8;
    localparam int W  = 16;
    localparam int IW = $clog2(P);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [P*W-1:0] load_data_i = '0;
    logic [IW-1:0]  rd_idx_i = '0;
    logic           done_o;
    logic [W-1:0]   rd_data_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    pfx_engine #(.P(P), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_data_i(load_data_i),
        .rd_idx_i(rd_idx_i), .done_o(done_o), .rd_data_o(rd_data_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [P*W-1:0] data);
        @(negedge clk);
        load_data_i = data;
        start_i     = 1'b1;
        @(negedge clk);
        start_i     = 1'b0;
        check("R6 done low after start", W'(done_o), W'(0));
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done_o && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check("R4 done reached", W'(done_o), W'(1));
    endtask

    task automatic check_results(input logic [P*W-1:0] data);
        logic [W-1:0] acc;
        acc = '0;
        for (int k = 0; k < P; k++) begin
            acc      = acc + data[k*W +: W];
            rd_idx_i = IW'(k);
            #1;
            check("R2 R3 R7 R8 R9 prefix sum", rd_data_o, acc);
        end
    endtask

    task automatic run(input logic [P*W-1:0] data);
        pulse_start(data);
        wait_done();
        check_results(data);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            check("R4 done sticky", W'(done_o), W'(1));
        end
    endtask

    initial begin
        logic [P*W-1:0] v;
        logic [15:0]    lfsr;
        repeat (3) @(negedge clk);
        check("R1 done after reset", W'(done_o), W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset release", W'(done_o), W'(0));

        for (int k = 0; k < P; k++) v[k*W +: W] = W'(1);
        run(v);
        for (int k = 0; k < P; k++) v[k*W +: W] = W'(k + 1);
        run(v);
        for (int k = 0; k < P; k++) v[k*W +: W] = '1;
        run(v);
        for (int p = 0; p < P; p++) begin
            v = '0;
            v[p*W +: W] = W'(16'h1234 + p);
            run(v);
        end
        lfsr = 16'hACE1;
        for (int r = 0; r < 20; r++) begin
            for (int k = 0; k < P; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v[k*W +: W] = lfsr;
            end
            run(v);
        end

        for (int k = 0; k < P; k++) v[k*W +: W] = W'(16'h7000 + 3 * k);
        for (int d = 0; d < 6; d++) begin
            logic [P*W-1:0] v2;
            pulse_start(v);
            repeat (d) @(negedge clk);
            for (int k = 0; k < P; k++) v2[k*W +: W] = W'(100 * k + d);
            pulse_start(v2);
            wait_done();
            begin
                logic [W-1:0] acc;
                acc = '0;
                for (int k = 0; k < P; k++) begin
                    acc      = acc + v2[k*W +: W];
                    rd_idx_i = IW'(k);
                    #1;
                    check("R5 restart discards old run", rd_data_o, acc);
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule